// File: doc/BRIEF.md
# Tagged Memory-Fill Sequencer

This block fills a region of memory with one byte value copied into every byte, and stores a 4-bit allocation tag for each 16-byte granule that the fill covers. A fill runs as three separate commands. The first is a prologue, which checks the operands and puts them into the form the later stages use. The second is a main stage, which writes all whole 64-byte blocks. The third is an epilogue, which writes whatever is left in 16-byte steps. Each command takes a destination address, a size and a fill byte. When it finishes, it returns the updated address, the updated size, a flag nibble and a fault code. Because the returned address and size always show how far the fill got, a stage that stops with an error can be resumed.

Writes leave through two valid/ready ports. The data port takes one 16-byte-aligned chunk per handshake, with byte enables. The tag port takes one granule address and a tag per handshake. Both ports return an error bit together with ready. A mode input chooses between two conventions for the address and size registers. In mode A the prologue moves the address to the end of the region and the size counts up toward zero as a negative number. In mode B the address counts up and the size counts down.

Top module: `tagfill_seq`

## Requirements
- R1: Every data write has a 16-byte-aligned address, has all 16 byte enables set, and carries the fill byte (`cmd_byte`) copied into all 16 bytes.
- R2: A prologue sets `fault_kind` to 1 (alignment) and makes no writes in two cases: the size is not a multiple of 16, or the size is nonzero and the address is not a multiple of 16. In that case the result address and size equal the inputs. An unaligned address with size zero is not a fault.
- R3: The prologue reads the size as unsigned. Any size above 0x7FFFFFFFFFFFFFF0 is replaced by that value before the checks and updates.
- R4: A prologue without a fault makes no writes.
  - In mode A (`cmd_mode_b`=0) it sets the flags to 0000, the address to address+size, and the size to −size.
  - In mode B it sets the flags to 0010 and returns the address and the clamped size unchanged.
- R5: The main stage writes all whole 64-byte blocks. Each block is four data writes at ascending granule addresses, then four tag writes at the same four addresses. Every tag equals bits 59:56 of the block's first address. A remaining amount below 64 bytes is left untouched.
- R6: Block placement and register updates depend on the mode.
  - In mode A a block starts at address+size, and the size rises by 16 for each data chunk accepted.
  - In mode B a block starts at the address. For each chunk accepted the address rises by 16 and the size falls by 16.
- R7: The epilogue writes everything that remains as 16-byte blocks. Each block is one data write followed by one tag write. A fault-free epilogue ends with size zero. The epilogue expects the size's sign to match the mode.
- R8: In the main and epilogue stages, when work remains and either the address or the size is not a multiple of 16, the stage reports `fault_kind` 1, makes no writes and leaves the registers unchanged.
- R9: A data write answered with `wr_err` stops the stage with `fault_kind` 2. No tag writes follow for that block. The address and size show only the chunks accepted without error.
- R10: A tag write answered with `tag_err` stops the stage with `fault_kind` 3. The address and size already include the whole block.
- R11: `done` pulses for exactly one cycle per accepted command. A command that arrives while `busy` is high is ignored. Stage code 3 is never accepted.
- R12: Once a write port raises valid, it holds valid and its address until ready is seen. The data port and the tag port are never valid in the same cycle.
- R13: After reset there are no writes, `done` and `busy` are low, and the result address, size, flags and fault code are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a stage (taken only when idle) |
| cmd_stage | input | 2 | 0 prologue, 1 main, 2 epilogue |
| cmd_mode_b | input | 1 | 0 selects mode A, 1 selects mode B |
| cmd_addr | input | 64 | Destination address register value |
| cmd_size | input | 64 | Size register value |
| cmd_byte | input | 8 | Fill byte |
| busy | output | 1 | A stage is in progress |
| done | output | 1 | One-cycle end-of-stage pulse |
| fault_kind | output | 2 | 0 none, 1 alignment, 2 data error, 3 tag error |
| res_addr | output | 64 | Updated address |
| res_size | output | 64 | Updated size |
| res_flags | output | 4 | Flag nibble written by the prologue |
| wr_valid | output | 1 | Data write request |
| wr_ready | input | 1 | Data write accepted |
| wr_addr | output | 64 | Chunk address |
| wr_data | output | 128 | Chunk data |
| wr_be | output | 16 | Byte enables |
| wr_err | input | 1 | Error response, valid with ready |
| tag_valid | output | 1 | Tag write request |
| tag_ready | input | 1 | Tag write accepted |
| tag_addr | output | 64 | Granule address |
| tag_val | output | 4 | Allocation tag |
| tag_err | input | 1 | Error response, valid with ready |

## Verification
The assertions rely on three assumptions about the inputs:
- `wr_err` and `tag_err` only matter in a cycle where the matching valid and ready are both high.
- An epilogue is started only with a size whose sign matches the mode; the zero-size check at its end depends on this.
- A size handed to a main or epilogue stage is one a prologue or earlier stage could have produced.

The stimulus keeps to these assumptions:
- Main and epilogue commands use the address and size that the preceding stage returned, apart from the dedicated misalignment case.
- Error responses are raised only in the handshake cycle of a chosen write.
- Ready is sometimes throttled so that the hold rules are exercised.

// File: rtl/tagfill_seq.sv
module tagfill_seq #(
  parameter int AW        = 64,
  parameter int BLK_BYTES = 64,
  parameter int TAG_LSB   = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_stage,
  input  logic          cmd_mode_b,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] cmd_size,
  input  logic [7:0]    cmd_byte,
  output logic          busy,
  output logic          done,
  output logic [1:0]    fault_kind,
  output logic [AW-1:0] res_addr,
  output logic [AW-1:0] res_size,
  output logic [3:0]    res_flags,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [127:0]  wr_data,
  output logic [15:0]   wr_be,
  input  logic          wr_err,
  output logic          tag_valid,
  input  logic          tag_ready,
  output logic [AW-1:0] tag_addr,
  output logic [3:0]    tag_val,
  input  logic          tag_err
);
  localparam int GB  = 16;
  localparam int NCH = BLK_BYTES / GB;
  localparam int CW  = $clog2(NCH + 1);
  localparam logic [AW-1:0] MAXS  = {1'b0, {(AW-5){1'b1}}, 4'h0};
  localparam logic [AW-1:0] BMASK = ~(AW'(BLK_BYTES - 1));
  localparam logic [AW-1:0] STEP  = AW'(GB);

  localparam logic [1:0] ST_PRO = 2'd0, ST_MAIN = 2'd1, ST_EPI = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_DATA, S_TAG} st_t;
  st_t st;

  logic [AW-1:0] r_addr, r_size, left, base;
  logic [3:0]    r_flags;
  logic [7:0]    r_byte;
  logic          r_modeb;
  logic [1:0]    r_stage;
  logic [1:0]    fk;
  logic [CW-1:0] cidx, tidx, nchk;
  logic          done_q;

  logic [AW-1:0] wpos, size_c, rem, amt;
  logic          p_bad, work, m_bad;

  assign wpos   = r_modeb ? r_addr : r_addr + r_size;
  assign size_c = (r_size > MAXS) ? MAXS : r_size;
  assign p_bad  = (size_c[3:0] != 4'h0) || ((size_c != '0) && (r_addr[3:0] != 4'h0));
  assign rem    = r_modeb ? r_size : -r_size;
  assign work   = $signed(rem) > 0;
  assign m_bad  = work && ((r_addr[3:0] | r_size[3:0]) != 4'h0);
  assign amt    = (r_stage == ST_MAIN) ? (rem & BMASK) : rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_addr  <= '0;
      r_size  <= '0;
      r_flags <= '0;
      r_byte  <= '0;
      r_modeb <= 1'b0;
      r_stage <= ST_PRO;
      fk      <= '0;
      left    <= '0;
      base    <= '0;
      cidx    <= '0;
      tidx    <= '0;
      nchk    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid && cmd_stage != 2'b11) begin
            r_addr  <= cmd_addr;
            r_size  <= cmd_size;
            r_byte  <= cmd_byte;
            r_modeb <= cmd_mode_b;
            r_stage <= cmd_stage;
            fk      <= '0;
            st      <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (r_stage == ST_PRO) begin
            if (p_bad) begin
              fk <= 2'd1;
            end else if (r_modeb) begin
              r_size  <= size_c;
              r_flags <= 4'b0010;
            end else begin
              r_addr  <= r_addr + size_c;
              r_size  <= -size_c;
              r_flags <= 4'b0000;
            end
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (m_bad) begin
            fk     <= 2'd1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (!work || amt == '0) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            left <= amt;
            base <= wpos;
            nchk <= (r_stage == ST_MAIN) ? CW'(NCH) : CW'(1);
            cidx <= '0;
            st   <= S_DATA;
          end
        end
        S_DATA: begin
          if (wr_ready) begin
            if (wr_err) begin
              fk     <= 2'd2;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              if (r_modeb) begin
                r_addr <= r_addr + STEP;
                r_size <= r_size - STEP;
              end else begin
                r_size <= r_size + STEP;
              end
              left <= left - STEP;
              if (cidx == nchk - CW'(1)) begin
                tidx <= '0;
                st   <= S_TAG;
              end else begin
                cidx <= cidx + CW'(1);
              end
            end
          end
        end
        S_TAG: begin
          if (tag_ready) begin
            if (tag_err) begin
              fk     <= 2'd3;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else if (tidx == nchk - CW'(1)) begin
              if (left == '0) begin
                done_q <= 1'b1;
                st     <= S_IDLE;
              end else begin
                base <= wpos;
                cidx <= '0;
                st   <= S_DATA;
              end
            end else begin
              tidx <= tidx + CW'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign fault_kind = fk;
  assign res_addr   = r_addr;
  assign res_size   = r_size;
  assign res_flags  = r_flags;

  assign wr_valid = (st == S_DATA);
  assign wr_addr  = base + (AW'(cidx) << 4);
  assign wr_data  = {16{r_byte}};
  assign wr_be    = '1;

  assign tag_valid = (st == S_TAG);
  assign tag_addr  = base + (AW'(tidx) << 4);
  assign tag_val   = base[TAG_LSB+3:TAG_LSB];
endmodule

// File: rtl/tagfill_seq_chk.sv
module tagfill_seq_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    fault_kind,
  input logic [1:0]    stage,
  input logic [AW-1:0] res_size,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic          tag_valid,
  input logic          tag_ready,
  input logic [AW-1:0] tag_addr
);
  p_wr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[3:0] == 4'h0);

  p_tag_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> tag_addr[3:0] == 4'h0);

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

  p_tag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && !tag_ready |=> tag_valid && $stable(tag_addr));

  p_one_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && tag_valid));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid && !tag_valid);

  p_epi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && stage == 2'd2 && fault_kind == 2'd0 |-> res_size == '0);
endmodule

bind tagfill_seq tagfill_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault_kind(fault_kind),
  .stage(r_stage), .res_size(res_size),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_addr(tag_addr)
);

// File: tb/tb_tagfill_seq.sv
module tb_tagfill_seq;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic cmd_valid, cmd_mode_b;
  logic [1:0] cmd_stage;
  logic [63:0] cmd_addr, cmd_size;
  logic [7:0] cmd_byte;
  logic busy, done;
  logic [1:0] fault_kind;
  logic [63:0] res_addr, res_size;
  logic [3:0] res_flags;
  logic wr_valid, wr_ready, wr_err;
  logic [63:0] wr_addr;
  logic [127:0] wr_data;
  logic [15:0] wr_be;
  logic tag_valid, tag_ready, tag_err;
  logic [63:0] tag_addr;
  logic [3:0] tag_val;

  tagfill_seq dut (.*);

  logic [68:0] exp_q[$];
  int checks = 0, errors = 0;
  int wr_cnt = 0, tag_cnt = 0, wr_err_at = -1, tag_err_at = -1, done_cnt = 0, cyc = 0;
  bit stall = 0, hs_bad = 0, pw_pend = 0, pt_pend = 0;
  logic [63:0] pw_addr, pt_addr;
  logic [7:0] exp_byte = 8'h00;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    wr_ready  = !stall || (cyc % 3 == 0);
    tag_ready = !stall || (cyc % 2 == 0);
    wr_err    = wr_valid && wr_ready && (wr_cnt == wr_err_at);
    tag_err   = tag_valid && tag_ready && (tag_cnt == tag_err_at);
  end

  // Monitor: pops expected writes as the design performs handshakes
  always @(posedge clk) begin
    logic [68:0] got, e;
    if (rst_n) begin
      if (wr_valid && tag_valid) hs_bad = 1;
      if (pw_pend && (!wr_valid || wr_addr != pw_addr)) hs_bad = 1;
      if (pt_pend && (!tag_valid || tag_addr != pt_addr)) hs_bad = 1;
      pw_pend = wr_valid && !wr_ready; pw_addr = wr_addr;
      pt_pend = tag_valid && !tag_ready; pt_addr = tag_addr;
      if (done) done_cnt++;
      if (wr_valid && wr_ready) begin
        got = {1'b0, 4'h0, wr_addr};
        chk(wr_data === {16{exp_byte}} && wr_be === 16'hFFFF, "R1", "fill data/enables",
            {wr_data}, {16{exp_byte}});
        if (exp_q.size() == 0) chk(0, "R5", "unexpected data write", got, 0);
        else begin e = exp_q.pop_front(); chk(got == e, "R6", "data write", got, e); end
        wr_cnt++;
      end
      if (tag_valid && tag_ready) begin
        got = {1'b1, tag_val, tag_addr};
        if (exp_q.size() == 0) chk(0, "R5", "unexpected tag write", got, 0);
        else begin e = exp_q.pop_front(); chk(got == e, "R5", "tag write", got, e); end
        tag_cnt++;
      end
    end
  end

  // Reference model: expected write stream and final registers
  task automatic model_fill(bit mb, logic [63:0] a, logic [63:0] s, int blk,
                            output logic [63:0] ra, output logic [63:0] rs, output int fk);
    logic [63:0] rem, amt, st;
    int wi = 0, ti = 0;
    fk = 0;
    rem = mb ? s : -s;
    amt = (blk == 64) ? (rem & ~64'h3F) : rem;
    while (amt != 0 && fk == 0) begin
      st = mb ? a : a + s;
      for (int c = 0; c < blk / 16; c++) begin
        exp_q.push_back({1'b0, 4'h0, st + 64'(16 * c)});
        if (wi == wr_err_at) begin fk = 2; break; end
        wi++;
        if (mb) begin a += 16; s -= 16; end else s += 16;
        amt -= 16;
      end
      if (fk == 0)
        for (int t = 0; t < blk / 16; t++) begin
          exp_q.push_back({1'b1, st[59:56], st + 64'(16 * t)});
          if (ti == tag_err_at) begin fk = 3; break; end
          ti++;
        end
    end
    ra = a; rs = s;
  endtask

  task automatic run(logic [1:0] stg, bit mb, logic [63:0] a, logic [63:0] s, logic [7:0] b,
                     bit inject, output logic [63:0] ra, output logic [63:0] rs,
                     output logic [3:0] rf, output int fk);
    int n = 0;
    exp_byte = b; wr_cnt = 0; tag_cnt = 0; done_cnt = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_stage = stg; cmd_mode_b = mb; cmd_addr = a; cmd_size = s; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (inject && n == 3) begin
        cmd_valid = 1; cmd_stage = 2'd0; cmd_addr = 64'h9998; cmd_size = 64'h18;
      end else cmd_valid = 0;
    end
    cmd_valid = 0;
    chk(n < 5000, "R11", "done seen", n, 5000);
    ra = res_addr; rs = res_size; rf = res_flags; fk = int'(fault_kind);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R11", "single done pulse", done_cnt, 1);
    chk(exp_q.size() == 0, "R5", "expected writes left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    logic [63:0] ra, rs, ea, es, a2, s2;
    logic [3:0] rf;
    int fk, efk;
    rst_n = 0; cmd_valid = 0; cmd_stage = 0; cmd_mode_b = 0;
    cmd_addr = 0; cmd_size = 0; cmd_byte = 0;
    wr_ready = 0; tag_ready = 0; wr_err = 0; tag_err = 0;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(!wr_valid && !tag_valid && !done && !busy, "R13", "reset outputs",
        {wr_valid, tag_valid, done, busy}, 0);
    chk(res_addr == 0 && res_size == 0 && res_flags == 0 && fault_kind == 0, "R13", "reset results",
        {res_addr, res_size}, 0);
    rst_n = 1;

    // Mode B full sequence, R4/R5/R6/R7
    a2 = 64'h0A00_0000_0000_1000;
    run(0, 1, a2, 64'h90, 8'h5C, 0, ra, rs, rf, fk);
    chk(rf == 4'b0010 && ra == a2 && rs == 64'h90 && fk == 0, "R4", "mode B prologue", {ra, rs}, {a2, 64'h90});
    stall = 1; // R12 throttled ready
    model_fill(1, ra, rs, 64, ea, es, efk);
    run(1, 1, ra, rs, 8'h5C, 0, ra, rs, rf, fk);
    chk(ra == ea && rs == es && fk == efk && rs == 64'h10, "R5", "mode B main result", {ra, rs}, {ea, es});
    stall = 0;
    model_fill(1, ra, rs, 16, ea, es, efk);
    run(2, 1, ra, rs, 8'h5C, 0, ra, rs, rf, fk);
    chk(ra == ea && rs == 0 && fk == 0, "R7", "mode B epilogue", {ra, rs}, {ea, 64'h0});

    // Mode A full sequence
    a2 = 64'h0500_0000_0000_2000;
    run(0, 0, a2, 64'hB0, 8'hA7, 0, ra, rs, rf, fk);
    chk(rf == 4'b0000 && ra == a2 + 64'hB0 && rs == -64'hB0 && fk == 0, "R4", "mode A prologue",
        {ra, rs}, {a2 + 64'hB0, -64'hB0});
    model_fill(0, ra, rs, 64, ea, es, efk);
    run(1, 0, ra, rs, 8'hA7, 0, ra, rs, rf, fk);
    chk(ra == ea && rs == es && rs == -64'h30 && fk == 0, "R6", "mode A main", {ra, rs}, {ea, es});
    model_fill(0, ra, rs, 16, ea, es, efk);
    run(2, 0, ra, rs, 8'hA7, 0, ra, rs, rf, fk);
    chk(rs == 0 && ra == a2 + 64'hB0 && fk == 0, "R7", "mode A epilogue", {ra, rs}, {a2 + 64'hB0, 64'h0});

    // R3 clamp of huge unsigned size
    run(0, 1, 64'h0, 64'hFFFF_FFFF_FFFF_FFF8, 8'h00, 0, ra, rs, rf, fk);
    chk(rs == 64'h7FFF_FFFF_FFFF_FFF0 && fk == 0 && rf == 4'b0010, "R3", "size clamp",
        rs, 64'h7FFF_FFFF_FFFF_FFF0);

    // R2 prologue alignment
    run(0, 1, 64'h1000, 64'h18, 8'h00, 0, ra, rs, rf, fk);
    chk(fk == 1 && ra == 64'h1000 && rs == 64'h18, "R2", "unaligned size", {fk, ra, rs}, {1, 64'h1000, 64'h18});
    run(0, 0, 64'h1008, 64'h20, 8'h00, 0, ra, rs, rf, fk);
    chk(fk == 1 && ra == 64'h1008 && rs == 64'h20, "R2", "unaligned address", {fk, ra}, {1, 64'h1008});
    run(0, 1, 64'h1008, 64'h0, 8'h00, 0, ra, rs, rf, fk);
    chk(fk == 0 && ra == 64'h1008 && rs == 0, "R2", "unaligned address zero size", fk, 0);

    // R8 main stage alignment, no writes
    run(1, 1, 64'h1008, 64'h40, 8'h11, 0, ra, rs, rf, fk);
    chk(fk == 1 && ra == 64'h1008 && rs == 64'h40, "R8", "main unaligned", {fk, ra, rs}, {1, 64'h1008, 64'h40});

    // R5 remainder below one block is left alone
    run(1, 1, 64'h6000, 64'h30, 8'h22, 0, ra, rs, rf, fk);
    chk(fk == 0 && ra == 64'h6000 && rs == 64'h30, "R5", "short main", {ra, rs}, {64'h6000, 64'h30});

    // R9 data write error on third chunk
    wr_err_at = 2;
    model_fill(1, 64'h3000, 64'h80, 64, ea, es, efk);
    run(1, 1, 64'h3000, 64'h80, 8'h33, 0, ra, rs, rf, fk);
    chk(fk == 2 && ra == 64'h3020 && rs == 64'h60 && ra == ea && efk == 2, "R9", "data error stop",
        {fk, ra, rs}, {2, 64'h3020, 64'h60});
    wr_err_at = -1;

    // R10 tag write error on second tag
    tag_err_at = 1;
    model_fill(1, 64'h4000, 64'h30, 16, ea, es, efk);
    run(2, 1, 64'h4000, 64'h30, 8'h44, 0, ra, rs, rf, fk);
    chk(fk == 3 && ra == 64'h4020 && rs == 64'h10 && rs == es, "R10", "tag error stop",
        {fk, ra, rs}, {3, 64'h4020, 64'h10});
    tag_err_at = -1;

    // R11 command while busy ignored
    stall = 1;
    model_fill(1, 64'h5000, 64'h80, 64, ea, es, efk);
    run(1, 1, 64'h5000, 64'h80, 8'h66, 1, ra, rs, rf, fk);
    chk(fk == 0 && ra == ea && rs == es, "R11", "busy command ignored", {ra, rs}, {ea, es});
    stall = 0;

    // R12 handshake rules observed throughout
    chk(!hs_bad, "R12", "valid hold / port exclusion", hs_bad, 0);
    finish_sim();
  end
endmodule